// File: doc/BRIEF.md
# Flash Hardware-Reset and Ready/Busy Sequencer

This block sits beside the command logic of a parallel NOR-style flash device and handles its hardware reset pin. The active-low pin arrives asynchronously. It passes through a two-flop synchronizer and is then qualified by a minimum pulse width. A qualified pulse does four things: it aborts any running program or erase, it holds the command state machine in array-read mode, it tristates the data bus, and it refuses every read or write.

The time to recover depends on what was running when the reset was qualified. If an embedded program or erase was active, the ready line stays low (busy) for a longer internal reset period. If the device was idle, ready stays high and a shorter internal period applies. After the pin rises again, accesses stay blocked for a further hold-off. The internal period must also have expired before they resume. The output-enable input can always force the data outputs into high impedance.

An aborted operation is not resumed. A sticky flag reports the abort, and the next command sequence clears it. All timing values are clock-cycle counts given as parameters, and each must be at least 1.

Top module: `flash_rst_seq`

## Requirements
- R1: A low pulse on `flash_reset_n` that the synchronized sample sees low for fewer than TRP consecutive cycles is ignored. No abort pulse is issued, `csm_to_read` and `op_aborted` do not change, and access returns once the pin is high again.
- R2: A pulse seen low for TRP consecutive cycles qualifies on that edge. `alg_abort` is high for exactly one cycle. `csm_to_read` is high from that cycle until recovery completes.
- R3: From the second clock edge after the pin falls until recovery completes, `rd_ok`, `wr_ok` and `data_oe` are 0 and `access_block` is 1.
- R4: If `alg_busy` is 1 at qualification, `ready` is 0 for exactly TREADY_EMB cycles counted from the qualifying edge, then returns to 1.
- R5: If `alg_busy` is 0 at qualification, `ready` stays 1. Access is still withheld until TREADY_IDLE cycles after the qualifying edge.
- R6: Access resumes TRH cycles after the edge on which the synchronized pin is first seen high again, or when the internal reset period ends, whichever is later.
- R7: With `oe_n` = 1, `data_oe` is 0 in every state.
- R8: `op_aborted` is set on qualification when `alg_busy` is 1. It is cleared by `cmd_start` only in normal operation. A `cmd_start` during reset is ignored.
- R9: A new low on the pin during the hold-off restarts the sequence. The internal period is reloaded, and the hold-off starts again from the next release.
- R10: In normal operation, `ready` = NOT `alg_busy`, `rd_ok` = `rd_req`, `wr_ok` = `wr_req`, and `data_oe` = NOT `oe_n`.
- R11: After system reset, `ready` follows `alg_busy`, and `access_block`, `alg_abort`, `csm_to_read` and `op_aborted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| flash_reset_n | input | 1 | Asynchronous active-low hardware reset pin |
| oe_n | input | 1 | Active-low output enable |
| rd_req | input | 1 | Read attempt from the bus |
| wr_req | input | 1 | Write attempt from the bus |
| alg_busy | input | 1 | Embedded program/erase engine running |
| cmd_start | input | 1 | A new command sequence begins |
| ready | output | 1 | Ready (1) / busy (0) indication |
| data_oe | output | 1 | Drive the data outputs |
| rd_ok | output | 1 | Read accepted |
| wr_ok | output | 1 | Write accepted |
| access_block | output | 1 | All accesses currently refused |
| alg_abort | output | 1 | One-cycle abort to the program/erase engine |
| csm_to_read | output | 1 | Hold the command state machine in array-read mode |
| op_aborted | output | 1 | Sticky: an operation was cut short by reset |

## Verification
The properties assume that `alg_busy`, `cmd_start` and the bus requests are synchronous to `clk`, and that every timing parameter is at least 1. The properties also assume the engine lowers `alg_busy` after the abort pulse. Only the reset pin is treated as asynchronous. The stimulus changes all inputs on falling clock edges. It drops `alg_busy` right after the abort is seen. Each reset pulse is held for a whole number of cycles, so the synchronizer latency and the qualification edge fall on known cycles.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_RST  = 2'd2,
        ST_HOLD = 2'd3
    } frs_state_e;

    function automatic int frs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/frs_timer.sv
module frs_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = load_val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R4
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
    import flash_rst_pkg::*;
#(
    parameter int TRP         = 4,
    parameter int TREADY_EMB  = 20,
    parameter int TREADY_IDLE = 8,
    parameter int TRH         = 5,
    parameter int RDY_W       = 5,
    parameter int HOLD_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_low_i,
    input  logic              alg_busy_i,
    input  logic              cmd_start_i,
    input  logic [RDY_W-1:0]  rdy_cnt_i,
    input  logic [HOLD_W-1:0] hold_cnt_i,
    output logic              rdy_load_o,
    output logic [RDY_W-1:0]  rdy_val_o,
    output logic              hold_load_o,
    output logic              access_ok_o,
    output logic              ready_o,
    output logic              abort_o,
    output logic              csm_read_o,
    output logic              aborted_o
);
    localparam int PW_W = $clog2(TRP + 1);

    typedef struct packed {
        frs_state_e        state;
        logic [PW_W-1:0]   pw;
        logic              emb;
        logic              abort;
        logic              aborted;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.abort    = 1'b0;
        rdy_load_o   = 1'b0;
        rdy_val_o    = RDY_W'(TREADY_IDLE);
        hold_load_o  = 1'b0;

        case (r_q.state)
            ST_RUN, ST_PEND: begin
                if (!pin_low_i) begin
                    r_d.state = ST_RUN;
                    r_d.pw    = '0;
                    if (r_q.state == ST_RUN && cmd_start_i) r_d.aborted = 1'b0;
                end else if (r_q.state == ST_PEND && r_q.pw == PW_W'(TRP - 1)
                             || (TRP == 1)) begin
                    r_d.state   = ST_RST;
                    r_d.pw      = '0;
                    r_d.abort   = 1'b1;
                    r_d.emb     = alg_busy_i;
                    r_d.aborted = r_q.aborted | alg_busy_i;
                    rdy_load_o  = 1'b1;
                    rdy_val_o   = alg_busy_i ? RDY_W'(TREADY_EMB) : RDY_W'(TREADY_IDLE);
                end else begin
                    r_d.state = ST_PEND;
                    r_d.pw    = r_q.pw + PW_W'(1);
                end
            end
            ST_RST: begin
                if (!pin_low_i) begin
                    r_d.state   = ST_HOLD;
                    hold_load_o = 1'b1;
                end
            end
            default: begin
                if (pin_low_i) begin
                    r_d.state  = ST_RST;
                    rdy_load_o = 1'b1;
                    rdy_val_o  = r_q.emb ? RDY_W'(TREADY_EMB) : RDY_W'(TREADY_IDLE);
                end else if (hold_cnt_i <= HOLD_W'(1) && rdy_cnt_i <= RDY_W'(1)) begin
                    r_d.state = ST_RUN;
                    r_d.emb   = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_RUN, pw: '0, emb: 1'b0, abort: 1'b0, aborted: 1'b0};
        else        r_q <= r_d;
    end

    assign access_ok_o = (r_q.state == ST_RUN) && !pin_low_i;
    assign ready_o     = (r_q.state == ST_RUN || r_q.state == ST_PEND) ? !alg_busy_i
                         : !(r_q.emb && rdy_cnt_i != '0);
    assign abort_o     = r_q.abort;
    assign csm_read_o  = (r_q.state == ST_RST || r_q.state == ST_HOLD);
    assign aborted_o   = r_q.aborted;

    AST_QUAL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RST && $past(r_q.state) == ST_PEND) |-> ($past(r_q.pw) == PW_W'(TRP - 1))); // R1
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.abort |=> !r_q.abort); // R2
    AST_LOW_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_low_i && r_q.state == ST_RUN) |=> (r_q.state != ST_RUN)); // R3
    AST_RESUME_TIMERS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && $past(r_q.state) == ST_HOLD) |-> (rdy_cnt_i == '0 && hold_cnt_i == '0)); // R6
    AST_FLAG_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.aborted) |-> r_q.abort); // R8
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import flash_rst_pkg::*;
#(
    parameter int TRP         = 4,
    parameter int TREADY_EMB  = 20,
    parameter int TREADY_IDLE = 8,
    parameter int TRH         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_reset_n,
    input  logic oe_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic alg_busy,
    input  logic cmd_start,
    output logic ready,
    output logic data_oe,
    output logic rd_ok,
    output logic wr_ok,
    output logic access_block,
    output logic alg_abort,
    output logic csm_to_read,
    output logic op_aborted
);
    localparam int RDY_MAX = frs_max(TREADY_EMB, TREADY_IDLE);
    localparam int RDY_W   = $clog2(RDY_MAX + 1);
    localparam int HOLD_W  = $clog2(TRH + 1);

    logic              pin_s;
    logic              rdy_load, hold_load, access_ok;
    logic [RDY_W-1:0]  rdy_val, rdy_cnt;
    logic [HOLD_W-1:0] hold_cnt;

    frs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(flash_reset_n), .sync_o(pin_s)
    );

    frs_timer #(.W(RDY_W)) u_rdy_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(rdy_load), .load_val_i(rdy_val), .cnt_o(rdy_cnt)
    );

    frs_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(hold_load), .load_val_i(HOLD_W'(TRH)), .cnt_o(hold_cnt)
    );

    frs_ctrl #(
        .TRP(TRP), .TREADY_EMB(TREADY_EMB), .TREADY_IDLE(TREADY_IDLE),
        .TRH(TRH), .RDY_W(RDY_W), .HOLD_W(HOLD_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_low_i(!pin_s), .alg_busy_i(alg_busy),
        .cmd_start_i(cmd_start), .rdy_cnt_i(rdy_cnt), .hold_cnt_i(hold_cnt),
        .rdy_load_o(rdy_load), .rdy_val_o(rdy_val), .hold_load_o(hold_load),
        .access_ok_o(access_ok), .ready_o(ready), .abort_o(alg_abort),
        .csm_read_o(csm_to_read), .aborted_o(op_aborted)
    );

    assign access_block = !access_ok;
    assign data_oe      = access_ok && !oe_n;
    assign rd_ok        = access_ok && rd_req;
    assign wr_ok        = access_ok && wr_req;

    AST_OE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !data_oe); // R7
endmodule

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;
    logic clk = 1'b0, rst_n = 1'b0, pin = 1'b1, oe_n = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0, alg_busy = 1'b0, cmd_start = 1'b0;
    logic ready, data_oe, rd_ok, wr_ok, access_block, alg_abort, csm_to_read, op_aborted;
    int checks = 0, errors = 0, t = 0, aborts = 0;

    always #5 clk = ~clk;

    flash_rst_seq #(.TRP(4), .TREADY_EMB(20), .TREADY_IDLE(8), .TRH(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .flash_reset_n(pin), .oe_n(oe_n), .rd_req(rd_req),
        .wr_req(wr_req), .alg_busy(alg_busy), .cmd_start(cmd_start), .ready(ready),
        .data_oe(data_oe), .rd_ok(rd_ok), .wr_ok(wr_ok), .access_block(access_block),
        .alg_abort(alg_abort), .csm_to_read(csm_to_read), .op_aborted(op_aborted)
    );

    always @(negedge clk) if (rst_n && alg_abort) aborts++;

    // {oe_n, rd_req, wr_req, alg_busy, exp data_oe, exp rd_ok, exp wr_ok, exp ready}
    localparam logic [7:0] VEC [0:7] = '{
        8'b0000_1001, 8'b1000_0001, 8'b0100_1101, 8'b0010_1011,
        8'b0111_1110, 8'b1111_0110, 8'b1001_0000, 8'b0001_1000
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, t, act, exp);
        end
    endtask

    task automatic upto(input int k);
        while (t < k) begin @(posedge clk); #2; t++; end
    endtask

    task automatic drive_at(input int k);
        upto(k); @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0; pin = 1'b1; alg_busy = 1'b0; cmd_start = 1'b0;
        rd_req = 1'b1; wr_req = 1'b1; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2; t = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sys_reset();
        // R11 reset state
        chk("R11 ready", ready, 1'b1);
        chk("R11 access_block", access_block, 1'b0);
        chk("R11 alg_abort", alg_abort, 1'b0);
        chk("R11 csm_to_read", csm_to_read, 1'b0);
        chk("R11 op_aborted", op_aborted, 1'b0);

        // R10 / R7 normal-mode vector walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {oe_n, rd_req, wr_req, alg_busy} = VEC[i][7:4];
            #1;
            chk("R10/R7 data_oe", data_oe, VEC[i][3]);
            chk("R10 rd_ok", rd_ok, VEC[i][2]);
            chk("R10 wr_ok", wr_ok, VEC[i][1]);
            chk("R10 ready", ready, VEC[i][0]);
        end

        // R1 glitch of TRP-1 cycles while an algorithm runs
        sys_reset(); alg_busy = 1'b1;
        drive_at(0); pin = 1'b0;
        drive_at(3); pin = 1'b1;
        upto(4);
        chk("R3 glitch blocks", access_block, 1'b1);
        upto(8);
        chk("R1 access back", access_block, 1'b0);
        chk("R1 no csm", csm_to_read, 1'b0);
        chk("R1 flag", op_aborted, 1'b0);
        chk("R1 no abort", aborts == 0, 1'b1);
        chk("R1 ready follows alg", ready, 1'b0);

        // R2 R3 R4 R6 R8 embedded case, long pulse
        sys_reset(); alg_busy = 1'b1; aborts = 0;
        drive_at(0); pin = 1'b0;
        upto(3);
        chk("R3 rd_ok", rd_ok, 1'b0);
        chk("R3 wr_ok", wr_ok, 1'b0);
        chk("R3 data_oe", data_oe, 1'b0);
        chk("R2 csm before qual", csm_to_read, 1'b0);
        upto(6);
        chk("R2 abort", alg_abort, 1'b1);
        chk("R2 csm", csm_to_read, 1'b1);
        chk("R8 flag set", op_aborted, 1'b1);
        chk("R4 busy", ready, 1'b0);
        drive_at(6); alg_busy = 1'b0; cmd_start = 1'b1;
        upto(7);
        chk("R2 abort one cycle", alg_abort, 1'b0);
        drive_at(7); cmd_start = 1'b0;
        upto(25);
        chk("R4 still busy", ready, 1'b0);
        upto(26);
        chk("R4 ready back", ready, 1'b1);
        chk("R8 cmd_start ignored", op_aborted, 1'b1);
        drive_at(30); pin = 1'b1;
        upto(37);
        chk("R6 hold-off", access_block, 1'b1);
        chk("R2 csm during hold", csm_to_read, 1'b1);
        upto(38);
        chk("R6 resumed", access_block, 1'b0);
        chk("R6 read accepted", rd_ok, 1'b1);
        chk("R2 csm released", csm_to_read, 1'b0);
        chk("R2 single abort", aborts == 1, 1'b1);
        drive_at(38); cmd_start = 1'b1;
        upto(39);
        chk("R8 flag cleared", op_aborted, 1'b0);
        drive_at(39); cmd_start = 1'b0;

        // R5 idle case, pulse of exactly TRP cycles
        sys_reset(); oe_n = 1'b1;
        drive_at(0); pin = 1'b0;
        drive_at(4); pin = 1'b1;
        upto(6);
        chk("R2 exact width qualifies", csm_to_read, 1'b1);
        chk("R5 ready high", ready, 1'b1);
        chk("R8 no flag when idle", op_aborted, 1'b0);
        upto(13);
        chk("R5 idle period", access_block, 1'b1);
        chk("R5 ready high late", ready, 1'b1);
        upto(14);
        chk("R5 resumed", access_block, 1'b0);
        chk("R7 oe_n high", data_oe, 1'b0);

        // R9 re-assertion during hold-off
        sys_reset();
        drive_at(0); pin = 1'b0;
        drive_at(20); pin = 1'b1;
        drive_at(24); pin = 1'b0;
        drive_at(26); pin = 1'b1;
        upto(30);
        chk("R9 blocked after restart", access_block, 1'b1);
        upto(34);
        chk("R9 still blocked", access_block, 1'b1);
        chk("R9 csm", csm_to_read, 1'b1);
        upto(35);
        chk("R9 resumed", access_block, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule